// File: doc/BRIEF.md
# Watchdog Timer with Selectable Post-Divider

This block is a watchdog that counts cycles of its own free-running clock. That clock is separate from the system clock, so the watchdog keeps counting while the system clock is stopped in the deepest low-power mode. A base counter marks off a fixed number of watchdog cycles. A post-divider then stretches the timeout by a ratio from 1 to 2048. The ratio is chosen by the same 3-bit code that sets the timer mode. When the timeout elapses, the block drives a device reset pulse.

Software keeps the chip alive by writing a control register in the system clock domain with bit 3 set. That write flips a toggle flop. A synchroniser carries the toggle into the watchdog domain, where it clears both the base counter and the post-divider. A static option input fixes whether the watchdog runs at all. Software has no way to change it.

Every pin is a plain control or status signal. Nothing carries a data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `wdog_core`

## Requirements
- R1: After power-on reset the output is low and both counters are zero. The select code 3'b000 then gives a timeout at the 2048*BASE_CYCLES-th watchdog clock edge after reset release.
- R2: The select code sets the post-divide ratio N as follows: 3'b111 gives 1, 3'b110 gives 2, 3'b101 gives 4, 3'b100 gives 8, 3'b011 gives 32, 3'b010 gives 128, 3'b001 gives 512 and 3'b000 gives 2048. The reset output rises at the BASE_CYCLES*N-th edge after counting starts.
- R3: A control write with bit 3 equal to 1 restarts the timeout. The clear reaches the watchdog domain within three watchdog cycles, and the next timeout follows BASE_CYCLES*N edges after the clear.
- R4: A control write with bit 3 equal to 0 has no effect, and the timeout comes at its original edge.
- R5: While the enable option is low, the output stays low and both counters are held at zero. Once the option goes high, the first timeout comes BASE_CYCLES*N edges later.
- R6: The reset output stays high for exactly PULSE_CYCLES watchdog cycles. Both counters are held at zero during the pulse, and the next timeout comes BASE_CYCLES*N edges after the pulse ends.
- R7: Counting and timeout still happen while the system clock is stopped.
- R8: A restart clears the post-divider progress as well as the base count. A restart partway through a long ratio therefore waits the full BASE_CYCLES*N edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wd_clk | input | 1 | Free-running watchdog clock |
| wd_por_n | input | 1 | Power-on reset for the watchdog domain, active low, asynchronous |
| wd_enable | input | 1 | Static enable option |
| div_sel | input | 3 | Post-divide select, shared with the timer mode field |
| sys_clk | input | 1 | System clock, which may stop |
| sys_rst_n | input | 1 | System domain reset, active low, asynchronous |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | CTL_W | Control write data; bit 3 is the restart bit |
| wd_reset_out | output | 1 | Device reset pulse, active high |

## Verification
Reset release, enabling and the end of a pulse are all in the watchdog domain, and each sets a fixed edge count. The output rises exactly BASE_CYCLES*N watchdog edges later, and it is high for exactly PULSE_CYCLES edges. The bench samples at falling watchdog edges, so each sample shows the state after the preceding rising edge, and it checks these counts exactly. A restart write crosses clock domains, which adds two or three watchdog cycles of uncertain phase. For those cases the bench accepts a narrow window around BASE_CYCLES*N. The window is still far from where a wrong design would fire: at the old deadline, or after only the rest of the post-divide count.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int SEL_W     = 3;
  localparam int MAX_RATIO = 2048;
  localparam int PRE_W     = $clog2(MAX_RATIO);

  typedef enum logic {WD_COUNT, WD_FIRE} wd_state_e;

  // Terminal count (ratio - 1) for a select code.
  // Codes with the top bit set halve per step; the rest quarter per step.
  function automatic logic [PRE_W-1:0] term_of(input logic [SEL_W-1:0] sel);
    int sh;
    if (sel[SEL_W-1]) sh = 7 - int'(sel);
    else              sh = 11 - 2 * int'(sel);
    return PRE_W'((32'd1 << sh) - 32'd1);
  endfunction
endpackage

// File: rtl/wdog_kick_sync.sv
module wdog_kick_sync #(
  parameter int CTL_W    = 4,
  parameter int KICK_BIT = 3,
  parameter int STAGES   = 2
) (
  input  logic             sys_clk,
  input  logic             sys_rst_n,
  input  logic             wr_en,
  input  logic [CTL_W-1:0] wr_data,
  input  logic             wd_clk,
  input  logic             wd_por_n,
  output logic             kick_pulse
);
  logic          req_tog;
  logic [STAGES:0] chain;

  // System side: each restart write flips the toggle.
  always_ff @(posedge sys_clk or negedge sys_rst_n) begin
    if (!sys_rst_n)                    req_tog <= 1'b0;
    else if (wr_en && wr_data[KICK_BIT]) req_tog <= ~req_tog;
  end

  // Watchdog side: synchroniser stages plus one edge-detect stage.
  always_ff @(posedge wd_clk or negedge wd_por_n) begin
    if (!wd_por_n) chain <= '0;
    else           chain <= {chain[STAGES-1:0], req_tog};
  end

  assign kick_pulse = chain[STAGES] ^ chain[STAGES-1];

  // Restart writes are spaced wider than a watchdog cycle, so a pulse is one cycle long.
  assert_kick_single_R3: assert property (@(posedge wd_clk) disable iff (!wd_por_n)
    kick_pulse |=> !kick_pulse);
endmodule

// File: rtl/wdog_base_cnt.sv
module wdog_base_cnt #(
  parameter int BASE_CYCLES = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clear,
  output logic tick,
  output logic idle
);
  localparam int BW = (BASE_CYCLES > 1) ? $clog2(BASE_CYCLES) : 1;
  localparam logic [BW-1:0] LAST = BW'(BASE_CYCLES - 1);

  logic [BW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (clear || !run)  cnt <= '0;
    else if (cnt == LAST)    cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end

  assign tick = run && !clear && (cnt == LAST);
  assign idle = (cnt == '0);

  assert_tick_isolated_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/wdog_post_div.sv
module wdog_post_div
  import wdog_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel,
  input  logic             clear,
  input  logic             tick_in,
  output logic             expire,
  output logic             idle
);
  logic [PRE_W-1:0] cnt;
  logic [PRE_W-1:0] term;

  assign term = term_of(sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (clear)     cnt <= '0;
    else if (tick_in) begin
      if (cnt >= term)  cnt <= '0;
      else              cnt <= cnt + 1'b1;
    end
  end

  assign expire = tick_in && !clear && (cnt >= term);
  assign idle   = (cnt == '0);

  assert_post_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_in && !clear && !expire) |=> (cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/wdog_core.sv
module wdog_core
  import wdog_pkg::*;
#(
  parameter int BASE_CYCLES  = 256,
  parameter int PULSE_CYCLES = 4,
  parameter int SYNC_STAGES  = 2,
  parameter int CTL_W        = 4,
  parameter int KICK_BIT     = 3
) (
  input  logic             wd_clk,
  input  logic             wd_por_n,
  input  logic             wd_enable,
  input  logic [2:0]       div_sel,
  input  logic             sys_clk,
  input  logic             sys_rst_n,
  input  logic             ctl_wr,
  input  logic [CTL_W-1:0] ctl_wdata,
  output logic             wd_reset_out
);
  localparam int PCW = (PULSE_CYCLES > 1) ? $clog2(PULSE_CYCLES) : 1;
  localparam logic [PCW-1:0] PLAST = PCW'(PULSE_CYCLES - 1);

  wd_state_e state;
  logic [PCW-1:0] pcnt;
  logic kick_pulse, tick, expire, base_idle, post_idle, clear_all;

  wdog_kick_sync #(.CTL_W(CTL_W), .KICK_BIT(KICK_BIT), .STAGES(SYNC_STAGES)) u_sync (
    .sys_clk(sys_clk), .sys_rst_n(sys_rst_n), .wr_en(ctl_wr), .wr_data(ctl_wdata),
    .wd_clk(wd_clk), .wd_por_n(wd_por_n), .kick_pulse(kick_pulse));

  assign clear_all = kick_pulse || (state == WD_FIRE);

  wdog_base_cnt #(.BASE_CYCLES(BASE_CYCLES)) u_base (
    .clk(wd_clk), .rst_n(wd_por_n), .run(wd_enable), .clear(clear_all),
    .tick(tick), .idle(base_idle));

  wdog_post_div u_post (
    .clk(wd_clk), .rst_n(wd_por_n), .sel(div_sel), .clear(clear_all),
    .tick_in(tick), .expire(expire), .idle(post_idle));

  always_ff @(posedge wd_clk or negedge wd_por_n) begin
    if (!wd_por_n) begin
      state <= WD_COUNT;
      pcnt  <= '0;
    end else if (!wd_enable) begin
      state <= WD_COUNT;
      pcnt  <= '0;
    end else begin
      case (state)
        WD_COUNT: if (expire) begin
          state <= WD_FIRE;
          pcnt  <= '0;
        end
        WD_FIRE: begin
          if (pcnt == PLAST) state <= WD_COUNT;
          pcnt <= pcnt + 1'b1;
        end
        default: state <= WD_COUNT;
      endcase
    end
  end

  assign wd_reset_out = (state == WD_FIRE);

  assert_disabled_quiet_R5: assert property (@(posedge wd_clk) disable iff (!wd_por_n)
    !wd_enable |=> !wd_reset_out);
  assert_hold_during_pulse_R6: assert property (@(posedge wd_clk) disable iff (!wd_por_n)
    wd_reset_out |-> (base_idle && post_idle));
  assert_kick_clears_R8: assert property (@(posedge wd_clk) disable iff (!wd_por_n)
    (kick_pulse && state == WD_COUNT) |=> (base_idle && post_idle));
  assert_fire_from_count_R2: assert property (@(posedge wd_clk) disable iff (!wd_por_n)
    $rose(wd_reset_out) |-> ($past(state) == WD_COUNT));
endmodule

// File: tb/test_wdog_core.sv
module test_wdog_core;
  localparam int WD_PERIOD  = 14;
  localparam int SYS_PERIOD = 10;
  localparam int BASE       = 8;
  localparam int PULSE      = 4;

  logic wd_clk = 1'b0, sys_clk = 1'b0, sys_run = 1'b1;
  logic wd_por_n = 1'b0, sys_rst_n = 1'b0, wd_enable = 1'b1;
  logic [2:0] div_sel = 3'b000;
  logic ctl_wr = 1'b0;
  logic [3:0] ctl_wdata = 4'h0;
  logic wd_reset_out;
  int n_checks = 0, n_fail = 0;

  wdog_core #(.BASE_CYCLES(BASE), .PULSE_CYCLES(PULSE)) i_wdog_core (
    .wd_clk(wd_clk), .wd_por_n(wd_por_n), .wd_enable(wd_enable), .div_sel(div_sel),
    .sys_clk(sys_clk), .sys_rst_n(sys_rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .wd_reset_out(wd_reset_out));

  always #(WD_PERIOD/2) wd_clk = ~wd_clk;
  always begin
    #(SYS_PERIOD/2);
    if (sys_run) sys_clk = ~sys_clk;
  end

  function automatic int ratio(input logic [2:0] s);
    case (s)
      3'b111: return 1;    3'b110: return 2;   3'b101: return 4;   3'b100: return 8;
      3'b011: return 32;   3'b010: return 128; 3'b001: return 512; default: return 2048;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  task automatic do_por(input logic [2:0] s, input logic en);
    wd_por_n = 1'b0; sys_rst_n = 1'b0; div_sel = s; wd_enable = en;
    repeat (3) @(negedge wd_clk);
    wd_por_n = 1'b1; sys_rst_n = 1'b1;
  endtask

  // Number of falling watchdog edges until the output is seen high (0 if never).
  task automatic wait_rise(input int limit, output int k);
    k = 0;
    for (int i = 1; i <= limit; i++) begin
      @(negedge wd_clk);
      if (wd_reset_out) begin k = i; return; end
    end
  endtask

  task automatic ctl_write(input logic [3:0] d);
    @(negedge sys_clk); ctl_wr = 1'b1; ctl_wdata = d;
    @(negedge sys_clk); ctl_wr = 1'b0; ctl_wdata = 4'h0;
  endtask

  task automatic t_reset();
    int k;
    wd_por_n = 1'b0; sys_rst_n = 1'b0; div_sel = 3'b000; wd_enable = 1'b1;
    repeat (5) @(negedge wd_clk);
    check(wd_reset_out == 1'b0, "R1 output low in reset", wd_reset_out, 0);
    wd_por_n = 1'b1; sys_rst_n = 1'b1;
    wait_rise(BASE*2048 + 20, k);
    check(k == BASE*2048, "R1 default ratio 2048 timeout", k, BASE*2048);
  endtask

  task automatic t_ratios();
    int k;
    for (int s = 1; s < 8; s++) begin
      do_por(3'(s), 1'b1);
      wait_rise(BASE*ratio(3'(s)) + 20, k);
      check(k == BASE*ratio(3'(s)), "R2 ratio decode", k, BASE*ratio(3'(s)));
    end
  endtask

  task automatic t_pulse();
    int k, w;
    do_por(3'b111, 1'b1);
    wait_rise(BASE + 20, k);
    check(k == BASE, "R6 first timeout", k, BASE);
    w = 1;
    for (int i = 0; i < 20; i++) begin
      @(negedge wd_clk);
      if (!wd_reset_out) break;
      w++;
    end
    check(w == PULSE, "R6 pulse width", w, PULSE);
    wait_rise(BASE + 20, k);
    check(k == BASE, "R6 restart after pulse", k, BASE);
  endtask

  task automatic t_kick();
    int k;
    do_por(3'b100, 1'b1);
    repeat (45) @(negedge wd_clk);
    ctl_write(4'b1000);
    wait_rise(200, k);
    check(k >= 62 && k <= 68, "R3 R8 restart clears both counters", k, 64);
  endtask

  task automatic t_zero_write();
    int k;
    do_por(3'b100, 1'b1);
    repeat (30) @(negedge wd_clk);
    ctl_write(4'b0111);
    wait_rise(200, k);
    check(k >= 31 && k <= 34, "R4 write with bit 3 clear ignored", k, 33);
  endtask

  task automatic t_disabled();
    int highs = 0, k;
    do_por(3'b111, 1'b0);
    for (int i = 0; i < 200; i++) begin
      @(negedge wd_clk);
      if (wd_reset_out) highs++;
    end
    check(highs == 0, "R5 disabled never fires", highs, 0);
    wd_enable = 1'b1;
    wait_rise(BASE + 20, k);
    check(k == BASE, "R5 counters held at zero while disabled", k, BASE);
  endtask

  task automatic t_stop();
    int k;
    do_por(3'b110, 1'b1);
    sys_run = 1'b0;
    wait_rise(2*BASE + 20, k);
    check(k == 2*BASE, "R7 timeout with system clock stopped", k, 2*BASE);
    sys_run = 1'b1;
  endtask

  initial begin
    #(WD_PERIOD * 60000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    t_reset();
    t_ratios();
    t_pulse();
    t_kick();
    t_zero_write();
    t_disabled();
    t_stop();
    summary();
    $finish;
  end
endmodule